// File: doc/BRIEF.md
# SD Card DAT0 Busy Monitor with Timeout

This block watches the DAT0 line of an SD/MMC card after the host has sent a command whose response is followed by a busy phase. While the card holds DAT0 low, the block reports a live busy flag. When the card releases the line, it records a sticky end-of-busy event that can raise an interrupt. A down-counting data timer runs only while the monitor is armed. If it reaches zero before the card releases DAT0, a sticky timeout flag is set instead, so software can treat the command as failed.

The command path gives a one-cycle strobe when a response has been received, together with a level that says whether this command has a busy phase. Software loads the timer reload value through a register-style write port. It computes that value as the timeout in milliseconds times the card clock in Hz, divided by 1000. After reset, the reload value is preset to a default busy window computed from parameters. Status is a 32-bit word with the flags at fixed bit positions. A mask word and a write-one-to-clear word use the same positions.

Top module: `busyGuard`

## Requirements
- R1: Status bit 20 is the inverse of DAT0 after a two-flop synchronizer: a change on `dat0In` shows on `statusOut[20]` after the second rising clock edge.
- R2: The live busy flag (bit 20) never asserts `irqOut`, whatever the mask.
- R3: Status bit 21 (end of busy) is set when the synchronized DAT0 goes from low to high while the monitor is armed. Once set, it stays set until it is cleared.
- R4: A DAT0 release while the monitor is not armed leaves bit 21 at 0. A `rspDone` strobe with `busyExpected` low does not arm the monitor.
- R5: A `rspDone` strobe with `busyExpected` high arms the monitor and loads the timer with the reload value L. If the card is still busy, status bit 3 (timeout) is set at the L-th rising edge after the arming edge.
- R6: A reload value of 0 disables the timeout: bit 3 never sets, however long busy lasts.
- R7: After reset the reload value is BUSY_MS_DEFAULT × CARD_CLK_HZ / 1000 (a 1000 ms busy window by default).
- R8: For one command, end of busy and timeout exclude each other. The first to occur disarms the monitor and stops the timer. If both fall on the same edge, end of busy wins.
- R9: `irqOut` is the OR over status bits 3 and 21 of each flag ANDed with the same bit of `maskIn`.
- R10: A 1 in `clearIn` at bit 3 or bit 21 clears that flag at the clock edge where it is sampled. Other flags are left alone.
- R11: After reset, bits 3 and 21 are 0 and `irqOut` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Card-side clock |
| rstN | input | 1 | Active-low synchronous reset |
| dat0In | input | 1 | DAT0 line, asynchronous to clk |
| rspDone | input | 1 | One-cycle strobe: command response received |
| busyExpected | input | 1 | Command in flight has a busy phase; sampled with rspDone |
| timerLoadEn | input | 1 | Write strobe for the timer reload value |
| timerLoadVal | input | TMR_W | Timer reload value, in clock cycles; 0 disables the timeout |
| maskIn | input | 32 | Interrupt enable per status bit |
| clearIn | input | 32 | Write-one-to-clear per status bit |
| statusOut | output | 32 | Bit 3 timeout, bit 20 live busy, bit 21 end of busy |
| irqOut | output | 1 | Interrupt request |

## Verification
Random commands draw the reload value and the busy length so that the busy-end edge lands sometimes before the expiry edge, sometimes after it, and sometimes on the same edge. This tells apart a correct priority and an exact count from one that is off by a cycle. A zero reload separates the disabled timer from a timer that wraps around. Releases of DAT0 while idle, and after a strobe without a busy phase, separate a properly armed monitor from one that latches every edge. Random masks, and a state where both sticky flags are set from two commands, separate per-bit masking and clearing from logic that treats the whole word as one.

// File: rtl/busyGuardPkg.sv
package busyGuardPkg;
  localparam int STAT_W   = 32;
  localparam int LIVE_BIT = 20;
  localparam int END_BIT  = 21;
  localparam int TMO_BIT  = 3;

  localparam logic [STAT_W-1:0] STICKY_BITS =
    (STAT_W'(1) << END_BIT) | (STAT_W'(1) << TMO_BIT);

  typedef struct packed {
    logic loadCnt;
    logic runCnt;
  } timerCmd_t;

  typedef enum logic {ST_IDLE, ST_ARMED} monState_t;
endpackage

// File: rtl/busyGuardTimer.sv
module busyGuardTimer
  import busyGuardPkg::*;
#(
  parameter int TMR_W = 32,
  parameter logic [TMR_W-1:0] RST_LOAD = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  timerCmd_t        cmd,
  input  logic             loadWr,
  input  logic [TMR_W-1:0] loadVal,
  output logic             expireHit
);
  localparam logic [TMR_W-1:0] ONE = TMR_W'(1);

  logic [TMR_W-1:0] loadReg;
  logic [TMR_W-1:0] cnt;
  logic             cntOn;

  // reload register, preset to the default busy window
  always_ff @(posedge clk) begin
    if (!rstN)       loadReg <= RST_LOAD;
    else if (loadWr) loadReg <= loadVal;
  end

  // down counter; a zero reload leaves it disabled
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt   <= '0;
      cntOn <= 1'b0;
    end else if (cmd.loadCnt) begin
      cnt   <= loadReg;
      cntOn <= (loadReg != '0);
    end else if (cmd.runCnt && cntOn && cnt != '0) begin
      cnt <= cnt - ONE;
    end
  end

  assign expireHit = cmd.runCnt && !cmd.loadCnt && cntOn && (cnt == ONE);

  AST_CNT_DOWN: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.runCnt && !cmd.loadCnt && cntOn && cnt > ONE) |=> cnt == $past(cnt) - ONE) // R5
    else $error("counter did not step down");
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!cmd.runCnt && !cmd.loadCnt) |=> $stable(cnt)) // R8
    else $error("counter moved while disarmed");
endmodule

// File: rtl/busyGuardCtrl.sv
module busyGuardCtrl
  import busyGuardPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              dat0In,
  input  logic              rspDone,
  input  logic              busyExpected,
  input  logic              expireHit,
  input  logic [STAT_W-1:0] maskIn,
  input  logic [STAT_W-1:0] clearIn,
  output timerCmd_t         timerCmd,
  output logic [STAT_W-1:0] statusOut,
  output logic              irqOut
);
  logic syncA, syncB, busyPrev;
  logic busyLive, busyFall;
  logic armStart, endSet, tmoSet;
  monState_t state, stateNext;
  logic [STAT_W-1:0] stickyVec, setVec, stickyNext;

  // two-flop synchronizer, line idles high (not busy)
  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncA    <= 1'b1;
      syncB    <= 1'b1;
      busyPrev <= 1'b0;
    end else begin
      syncA    <= dat0In;
      syncB    <= syncA;
      busyPrev <= busyLive;
    end
  end

  assign busyLive = ~syncB;
  assign busyFall = busyPrev & ~busyLive;

  assign armStart = rspDone & busyExpected;
  assign endSet   = (state == ST_ARMED) & busyFall;
  assign tmoSet   = (state == ST_ARMED) & expireHit & ~busyFall;

  always_comb begin
    stateNext = state;
    if (armStart)             stateNext = ST_ARMED;
    else if (endSet || tmoSet) stateNext = ST_IDLE;
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    timerCmd.loadCnt = armStart;
    timerCmd.runCnt  = (state == ST_ARMED);
  end

  // sticky flags: a new event wins over a clear in the same cycle
  always_comb begin
    setVec = '0;
    setVec[END_BIT] = endSet;
    setVec[TMO_BIT] = tmoSet;
    stickyNext = ((stickyVec & ~clearIn) | setVec) & STICKY_BITS;
  end

  always_ff @(posedge clk) begin
    if (!rstN) stickyVec <= '0;
    else       stickyVec <= stickyNext;
  end

  always_comb begin
    statusOut = stickyVec;
    statusOut[LIVE_BIT] = busyLive;
  end

  assign irqOut = |(stickyVec & maskIn);

  AST_END_DISARMS: assert property (@(posedge clk) disable iff (!rstN)
    (endSet && !armStart) |=> state == ST_IDLE) // R8
    else $error("monitor stayed armed after busy end");
  AST_ONE_EVENT: assert property (@(posedge clk) disable iff (!rstN)
    !($rose(stickyVec[END_BIT]) && $rose(stickyVec[TMO_BIT]))) // R8
    else $error("both events in one cycle");
  AST_END_ONLY_ARMED: assert property (@(posedge clk) disable iff (!rstN)
    $rose(stickyVec[END_BIT]) |-> $past(state) == ST_ARMED) // R4
    else $error("busy end recorded while idle");
  AST_CLEAR_END: assert property (@(posedge clk) disable iff (!rstN)
    (clearIn[END_BIT] && !endSet) |=> !stickyVec[END_BIT]) // R10
    else $error("clear did not drop busy end");
  AST_CLEAR_TMO: assert property (@(posedge clk) disable iff (!rstN)
    (clearIn[TMO_BIT] && !tmoSet) |=> !stickyVec[TMO_BIT]) // R10
    else $error("clear did not drop timeout");
endmodule

// File: rtl/busyGuard.sv
module busyGuard
  import busyGuardPkg::*;
#(
  parameter int CARD_CLK_HZ     = 25_000_000,
  parameter int BUSY_MS_DEFAULT = 1000,
  parameter int TMR_W           = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              dat0In,
  input  logic              rspDone,
  input  logic              busyExpected,
  input  logic              timerLoadEn,
  input  logic [TMR_W-1:0]  timerLoadVal,
  input  logic [STAT_W-1:0] maskIn,
  input  logic [STAT_W-1:0] clearIn,
  output logic [STAT_W-1:0] statusOut,
  output logic              irqOut
);
  localparam logic [63:0] DEF_PROD =
    64'(BUSY_MS_DEFAULT) * 64'(CARD_CLK_HZ) / 64'd1000;
  localparam logic [TMR_W-1:0] DEF_LOAD = DEF_PROD[TMR_W-1:0];

  timerCmd_t timerCmd;
  logic      expireHit;

  busyGuardCtrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .dat0In       (dat0In),
    .rspDone      (rspDone),
    .busyExpected (busyExpected),
    .expireHit    (expireHit),
    .maskIn       (maskIn),
    .clearIn      (clearIn),
    .timerCmd     (timerCmd),
    .statusOut    (statusOut),
    .irqOut       (irqOut)
  );

  busyGuardTimer #(
    .TMR_W    (TMR_W),
    .RST_LOAD (DEF_LOAD)
  ) u_timer (
    .clk       (clk),
    .rstN      (rstN),
    .cmd       (timerCmd),
    .loadWr    (timerLoadEn),
    .loadVal   (timerLoadVal),
    .expireHit (expireHit)
  );
endmodule

// File: tb/sim_busyGuard.sv
`timescale 1ns/1ps
module sim_busyGuard;
  localparam int CLK_HZ  = 64;
  localparam int DEF_MS  = 1000;
  localparam int DEF_CYC = DEF_MS * CLK_HZ / 1000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic dat0In = 1'b1;
  logic rspDone = 1'b0;
  logic busyExpected = 1'b0;
  logic timerLoadEn = 1'b0;
  logic [31:0] timerLoadVal = '0;
  logic [31:0] maskIn = '0;
  logic [31:0] clearIn = '0;
  logic [31:0] statusOut;
  logic irqOut;

  int nTests = 0;
  int nFail = 0;
  bit doneFlag = 0;

  always #2 clk = ~clk;

  busyGuard #(.CARD_CLK_HZ(CLK_HZ), .BUSY_MS_DEFAULT(DEF_MS), .TMR_W(32)) u0 (
    .clk(clk), .rstN(rstN), .dat0In(dat0In), .rspDone(rspDone),
    .busyExpected(busyExpected), .timerLoadEn(timerLoadEn),
    .timerLoadVal(timerLoadVal), .maskIn(maskIn), .clearIn(clearIn),
    .statusOut(statusOut), .irqOut(irqOut)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic armCmd(bit bexp);
    rspDone = 1'b1;
    busyExpected = bexp;
    step(1);
    rspDone = 1'b0;
    busyExpected = 1'b0;
  endtask

  // busy held; optional reload; arm; release after d edges (d<0: hold)
  task automatic doCmd(int l, int d, bit doLoad);
    dat0In = 1'b0;
    step(4);
    if (doLoad) begin
      timerLoadEn = 1'b1;
      timerLoadVal = 32'(l);
      step(1);
      timerLoadEn = 1'b0;
    end
    armCmd(1'b1);
    if (d >= 0) begin
      step(d);
      dat0In = 1'b1;
    end
  endtask

  task automatic clearAll();
    clearIn = 32'h0020_0008;
    step(1);
    clearIn = '0;
  endtask

  function automatic bit expEnd(int l, int d);
    return (l == 0) || (d + 3 <= l);
  endfunction

  initial begin
    step(3);
    rstN = 1'b1;
    step(1);
    // R11 reset state
    chk("R11 status after reset", statusOut, 32'h0);
    chk("R11 irq after reset", 32'(irqOut), 32'h0);

    // R7 default reload window
    maskIn = 32'hFFFF_FFFF;
    doCmd(0, -1, 1'b0);
    step(DEF_CYC - 1);
    chk("R7 no timeout one cycle early", 32'(statusOut[3]), 32'h0);
    chk("R2 live busy raises no irq", 32'(irqOut), 32'h0);
    step(1);
    chk("R7 timeout at default window", 32'(statusOut[3]), 32'h1);
    dat0In = 1'b1;
    step(4);
    chk("R8 release after timeout ignored", 32'(statusOut[21]), 32'h0);
    clearAll();
    chk("R10 both flags cleared", statusOut & 32'h0020_0008, 32'h0);

    // R1 synchronizer latency
    dat0In = 1'b0;
    step(1);
    chk("R1 live busy not after one edge", 32'(statusOut[20]), 32'h0);
    step(1);
    chk("R1 live busy after two edges", 32'(statusOut[20]), 32'h1);
    chk("R2 irq stays low with full mask", 32'(irqOut), 32'h0);
    dat0In = 1'b1;
    step(1);
    chk("R1 still busy after one edge", 32'(statusOut[20]), 32'h1);
    step(1);
    chk("R1 released after two edges", 32'(statusOut[20]), 32'h0);
    step(2);
    chk("R4 release while idle ignored", 32'(statusOut[21]), 32'h0);

    // R4 strobe without busy phase does not arm
    dat0In = 1'b0;
    step(4);
    armCmd(1'b0);
    step(2);
    dat0In = 1'b1;
    step(6);
    chk("R4 strobe without busy phase", 32'(statusOut[21]), 32'h0);

    // R5 exact expiry with L=10
    doCmd(10, -1, 1'b1);
    step(9);
    chk("R5 no timeout at L-1", 32'(statusOut[3]), 32'h0);
    step(1);
    chk("R5 timeout at L", 32'(statusOut[3]), 32'h1);
    chk("R9 irq from timeout", 32'(irqOut), 32'h1);
    dat0In = 1'b1;
    step(4);
    chk("R8 end flag stays clear", 32'(statusOut[21]), 32'h0);

    // R3 end on second command, both flags now set; R10 partial clear
    doCmd(30, 5, 1'b1);
    step(4);
    chk("R3 end of busy set", 32'(statusOut[21]), 32'h1);
    step(20);
    chk("R3 end of busy sticky", 32'(statusOut[21]), 32'h1);
    maskIn = 32'h0000_0008;
    clearIn = 32'h0020_0000;
    step(1);
    clearIn = '0;
    chk("R10 end cleared alone", statusOut & 32'h0020_0008, 32'h0000_0008);
    chk("R9 irq masked to timeout only", 32'(irqOut), 32'h1);
    maskIn = 32'h0020_0000;
    step(1);
    chk("R9 timeout masked off", 32'(irqOut), 32'h0);
    clearAll();

    // R6 zero reload never times out
    doCmd(0, -1, 1'b1);
    step(120);
    chk("R6 zero reload disables timeout", 32'(statusOut[3]), 32'h0);
    dat0In = 1'b1;
    step(4);
    chk("R6 end still seen", 32'(statusOut[21]), 32'h1);
    clearAll();

    // R8 tie: end edge and expiry on the same edge
    doCmd(8, 5, 1'b1);
    step(15);
    chk("R8 tie end wins", statusOut & 32'h0020_0008, 32'h0020_0000);
    clearAll();
    doCmd(8, 6, 1'b1);
    step(15);
    chk("R8 one late gives timeout", statusOut & 32'h0020_0008, 32'h0000_0008);
    clearAll();

    // random commands
    void'($urandom(32'd1234));
    for (int i = 0; i < 40; i++) begin
      int l;
      int d;
      bit e;
      bit expIrq;
      l = int'($urandom_range(0, 40));
      d = int'($urandom_range(0, 45));
      maskIn = ($urandom_range(0, 1) != 0 ? 32'h0020_0000 : 32'h0) |
               ($urandom_range(0, 1) != 0 ? 32'h0000_0008 : 32'h0);
      e = expEnd(l, d);
      expIrq = (e && maskIn[21]) || (!e && maskIn[3]);
      doCmd(l, d, 1'b1);
      step(50);
      chk("R8 random event select", statusOut & 32'h0020_0008,
          e ? 32'h0020_0000 : 32'h0000_0008);
      chk("R9 random irq", 32'(irqOut), 32'(expIrq));
      clearAll();
      chk("R10 random clear", 32'(irqOut), 32'h0);
    end

    if (!doneFlag) begin
      doneFlag = 1;
      $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!doneFlag) begin
      doneFlag = 1;
      nTests++;
      nFail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end
endmodule